// File: doc/BRIEF.md
# Chunked Bitmap Rank Indexer

This block turns a bit position in a large bitmap into a memory index. The bitmap is kept as fixed-width chunks, and beside each chunk the block keeps a stored count of the ones in every chunk that comes before it. A lookup names a bit position. The block reads that position's chunk and stored count, and returns three results: the bit's value, the exclusive rank (stored count plus the ones before the bit inside its chunk), and the inclusive rank (the same, plus the bit itself). A trie search engine uses the exclusive rank to find the segment that holds a node's children, and the inclusive rank to find the node's next-hop entry.

The bitmap and count memories are inside the block. They are filled through a load port. Software streams the chunks in ascending order, and a load sequencer adds up the running count of ones as it goes, so no offsets have to be precomputed. A small state machine has two states. In ST_IDLE the block answers lookups. In ST_LOAD it writes chunks. A load-start pulse moves it from ST_IDLE to ST_LOAD and clears the chunk pointer and the running sum. After the final chunk has been written it moves back from ST_LOAD to ST_IDLE without any further input. A lookup is answered one cycle after it is accepted.

Top module: `rank_indexer`

## Requirements
- R1: The index is split so that its upper IDX_W-log2(CHUNK_W) bits select the chunk and its low log2(CHUNK_W) bits give the position p within the chunk. Position p is data bit CHUNK_W-1-p of the loaded word, so the word's most significant bit is the leftmost bitmap bit of that chunk.
- R2: rsp_bit equals the bitmap value at the requested index.
- R3: rsp_excl equals the number of ones in all earlier chunks plus the ones at positions strictly below p in the addressed chunk.
- R4: rsp_incl equals rsp_excl plus the value of the requested bit, i.e. the ones at and before the requested position.
- R5: rsp_valid is high in exactly the cycle after an accepted request, for one cycle per request. Requests in consecutive cycles give responses in consecutive cycles.
- R6: In ST_IDLE, ld_start enters ST_LOAD with the chunk pointer and running sum at zero. Each ld_valid cycle in ST_LOAD writes ld_data to the next chunk in ascending order, together with an offset equal to the ones in the chunks written earlier in the same load.
- R7: After the last chunk (index 2^(IDX_W-log2(CHUNK_W))-1) is written, the block is back in ST_IDLE and accepts lookups in the next cycle.
- R8: A request is ignored (no rsp_valid follows) while the block is in ST_LOAD, and also in a cycle where ld_start is high.
- R9: ld_valid in ST_IDLE writes nothing; later lookups return the earlier contents.
- R10: During reset the block is in ST_IDLE, and rsp_valid, rsp_bit, rsp_excl and rsp_incl are zero.
- R11: The rank outputs are IDX_W+1 bits wide. With an all-ones bitmap, the inclusive rank of the last index is exactly 2^IDX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Begin a load of all chunks |
| ld_valid | input | 1 | ld_data holds the next chunk |
| ld_data | input | CHUNK_W | Chunk contents, MSB is leftmost bit |
| req_valid | input | 1 | Lookup request |
| req_idx | input | IDX_W | Bit position to look up |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_bit | output | 1 | Value of the requested bit |
| rsp_excl | output | IDX_W+1 | Ones before the requested bit |
| rsp_incl | output | IDX_W+1 | Ones at and before the requested bit |

## Verification
All three lookup results and rsp_valid appear one cycle after the request is accepted. The bench drives each request on a falling edge and samples the response on the next falling edge, which is after the single registered stage has updated. A load write takes effect at the rising edge of its ld_valid cycle, and the return to ST_IDLE happens at that same edge. For this reason the bench checks that rsp_valid stays low on the falling edge after each load cycle, and only then starts issuing lookups. Expected ranks come from a bench model that counts bits of the loaded words one at a time; it does not use stored offsets.

// File: rtl/rank_pkg.sv
package rank_pkg;

    // Load sequencer states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_e;

endpackage

// File: rtl/rank_chunk_store.sv
module rank_chunk_store #(
    parameter int CHUNK_W = 32,
    parameter int CH_AW   = 11,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               we,
    input  logic [CH_AW-1:0]   waddr,
    input  logic [CHUNK_W-1:0] wdata,
    input  logic [OFS_W-1:0]   wofs,
    input  logic [CH_AW-1:0]   raddr,
    output logic [CHUNK_W-1:0] rdata,
    output logic [OFS_W-1:0]   rofs
);
    localparam int NCH = 1 << CH_AW;

    logic [CHUNK_W-1:0] bits_mem [NCH];
    logic [OFS_W-1:0]   ofs_mem  [NCH];

    // Chunk word and its prefix count are written together
    always_ff @(posedge clk) begin
        if (we) begin
            bits_mem[waddr] <= wdata;
            ofs_mem[waddr]  <= wofs;
        end
    end

    // Asynchronous read feeds the registered response stage in the top
    always_comb begin
        rdata = bits_mem[raddr];
        rofs  = ofs_mem[raddr];
    end

endmodule

// File: rtl/rank_masked_count.sv
module rank_masked_count #(
    parameter int CHUNK_W = 32,
    parameter int POS_W   = 5
) (
    input  logic [CHUNK_W-1:0] word,
    input  logic [POS_W-1:0]   pos,
    output logic               bit_o,
    output logic [POS_W:0]     cnt_excl,
    output logic [POS_W:0]     cnt_incl
);
    localparam int CNT_W = POS_W + 1;

    logic [CHUNK_W-1:0] m_ex;
    logic [CHUNK_W-1:0] m_in;
    logic [CHUNK_W-1:0] hit_ex;
    logic [CHUNK_W-1:0] hit_in;

    // Word bit k sits at chunk position CHUNK_W-1-k (MSB is leftmost)
    for (genvar k = 0; k < CHUNK_W; k++) begin : g_mask
        localparam int P = CHUNK_W - 1 - k;
        assign m_ex[k] = (pos >  POS_W'(P));
        assign m_in[k] = (pos >= POS_W'(P));
    end

    assign hit_ex = word & m_ex;
    assign hit_in = word & m_in;
    assign bit_o  = |(word & m_in & ~m_ex);

    always_comb begin
        cnt_excl = '0;
        cnt_incl = '0;
        for (int k = 0; k < CHUNK_W; k++) begin
            cnt_excl = cnt_excl + CNT_W'(hit_ex[k]);
            cnt_incl = cnt_incl + CNT_W'(hit_in[k]);
        end
    end

endmodule

// File: rtl/rank_load_seq.sv
module rank_load_seq
    import rank_pkg::*;
#(
    parameter int CHUNK_W = 32,
    parameter int CH_AW   = 11,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_start,
    input  logic               ld_valid,
    input  logic [CHUNK_W-1:0] ld_data,
    output logic               we,
    output logic [CH_AW-1:0]   waddr,
    output logic [OFS_W-1:0]   wofs,
    output logic               idle
);
    localparam int ONES_W = $clog2(CHUNK_W) + 1;

    ld_state_e        state_q, state_d;
    logic [CH_AW-1:0] ptr_q;
    logic [OFS_W-1:0] sum_q;
    logic [ONES_W-1:0] ones;
    logic             last_chunk;

    always_comb begin
        ones = '0;
        for (int k = 0; k < CHUNK_W; k++) begin
            ones = ones + ONES_W'(ld_data[k]);
        end
    end

    assign last_chunk = (ptr_q == {CH_AW{1'b1}});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->LOAD on start, LOAD->IDLE after final chunk
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_start) state_d = ST_LOAD;
            ST_LOAD: if (ld_valid && last_chunk) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Chunk pointer and running count of ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sum_q <= '0;
        end else if (state_q == ST_IDLE && ld_start) begin
            ptr_q <= '0;
            sum_q <= '0;
        end else if (we) begin
            ptr_q <= ptr_q + 1'b1;
            sum_q <= sum_q + OFS_W'(ones);
        end
    end

    // Outputs
    always_comb begin
        we    = (state_q == ST_LOAD) && ld_valid;
        waddr = ptr_q;
        wofs  = sum_q;
        idle  = (state_q == ST_IDLE);
    end

    AST_LOAD_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LOAD) |-> (ptr_q == '0 && sum_q == '0)); // R6
    AST_LOAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && ld_valid && last_chunk) |=> (state_q == ST_IDLE)); // R7
    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(ptr_q) || (ptr_q == '0)); // R9

endmodule

// File: rtl/rank_indexer.sv
module rank_indexer #(
    parameter int IDX_W   = 16,
    parameter int CHUNK_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_start,
    input  logic               ld_valid,
    input  logic [CHUNK_W-1:0] ld_data,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_idx,
    output logic               rsp_valid,
    output logic               rsp_bit,
    output logic [IDX_W:0]     rsp_excl,
    output logic [IDX_W:0]     rsp_incl
);
    localparam int POS_W  = $clog2(CHUNK_W);
    localparam int CH_AW  = IDX_W - POS_W;
    localparam int OFS_W  = IDX_W;
    localparam int RANK_W = IDX_W + 1;

    logic               we;
    logic [CH_AW-1:0]   waddr;
    logic [OFS_W-1:0]   wofs;
    logic               idle;
    logic [CH_AW-1:0]   raddr;
    logic [POS_W-1:0]   pos;
    logic [CHUNK_W-1:0] rdata;
    logic [OFS_W-1:0]   rofs;
    logic               hit_bit;
    logic [POS_W:0]     cnt_excl;
    logic [POS_W:0]     cnt_incl;
    logic               accept;
    logic [RANK_W-1:0]  excl_d;
    logic [RANK_W-1:0]  incl_d;

    assign raddr  = req_idx[IDX_W-1:POS_W];
    assign pos    = req_idx[POS_W-1:0];
    assign accept = req_valid && idle && !ld_start;

    rank_load_seq #(
        .CHUNK_W (CHUNK_W),
        .CH_AW   (CH_AW),
        .OFS_W   (OFS_W)
    ) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_start (ld_start),
        .ld_valid (ld_valid),
        .ld_data  (ld_data),
        .we       (we),
        .waddr    (waddr),
        .wofs     (wofs),
        .idle     (idle)
    );

    rank_chunk_store #(
        .CHUNK_W (CHUNK_W),
        .CH_AW   (CH_AW),
        .OFS_W   (OFS_W)
    ) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (ld_data),
        .wofs  (wofs),
        .raddr (raddr),
        .rdata (rdata),
        .rofs  (rofs)
    );

    rank_masked_count #(
        .CHUNK_W (CHUNK_W),
        .POS_W   (POS_W)
    ) u_count (
        .word     (rdata),
        .pos      (pos),
        .bit_o    (hit_bit),
        .cnt_excl (cnt_excl),
        .cnt_incl (cnt_incl)
    );

    assign excl_d = RANK_W'(rofs) + RANK_W'(cnt_excl);
    assign incl_d = RANK_W'(rofs) + RANK_W'(cnt_incl);

    // Registered response stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_bit   <= 1'b0;
            rsp_excl  <= '0;
            rsp_incl  <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_bit  <= hit_bit;
                rsp_excl <= excl_d;
                rsp_incl <= incl_d;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R5
    AST_NO_RSP_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(idle)); // R8
    AST_INCL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_incl - rsp_excl) == RANK_W'(rsp_bit))); // R4
    AST_EXCL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (cnt_excl <= {1'b0, pos})); // R3

endmodule

// File: tb/tb_rank_indexer.sv
module tb_rank_indexer;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int CHUNK_W    = 32;
    localparam int NCH        = (1 << IDX_W) / CHUNK_W;
    localparam int NLOOK      = 14;
    localparam logic [IDX_W-1:0] LOOK_IDX [NLOOK] = '{
        8'd0, 8'd31, 8'd32, 8'd63, 8'd64, 8'd65, 8'd95,
        8'd96, 8'd97, 8'd128, 8'd160, 8'd200, 8'd224, 8'd255
    };
    localparam logic [CHUNK_W-1:0] IMG_A [NCH] = '{
        32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'hAAAA_AAAA,
        32'h0000_0001, 32'hF0F0_F0F0, 32'h1234_5678, 32'h8000_0000
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ld_start = 1'b0;
    logic               ld_valid = 1'b0;
    logic [CHUNK_W-1:0] ld_data = '0;
    logic               req_valid = 1'b0;
    logic [IDX_W-1:0]   req_idx = '0;
    logic               rsp_valid;
    logic               rsp_bit;
    logic [IDX_W:0]     rsp_excl;
    logic [IDX_W:0]     rsp_incl;

    int checks = 0;
    int failures = 0;
    logic [CHUNK_W-1:0] img [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    rank_indexer #(.IDX_W(IDX_W), .CHUNK_W(CHUNK_W)) dut (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_valid(ld_valid),
        .ld_data(ld_data), .req_valid(req_valid), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_bit(rsp_bit),
        .rsp_excl(rsp_excl), .rsp_incl(rsp_incl)
    );

    function automatic logic model_bit(input int b);
        return img[b / CHUNK_W][CHUNK_W - 1 - (b % CHUNK_W)];
    endfunction

    function automatic int model_rank(input int idx, input bit incl);
        int c = 0;
        for (int b = 0; b < idx; b++) c += int'(model_bit(b));
        if (incl) c += int'(model_bit(idx));
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input bit use_a, input bit poke_req);
        @(negedge clk);
        ld_start  = 1'b1;
        req_valid = poke_req;
        req_idx   = '0;
        @(negedge clk);
        ld_start = 1'b0;
        check(rsp_valid == 1'b0, "R8 start cycle", int'(rsp_valid), 0);
        for (int c = 0; c < NCH; c++) begin
            img[c]   = use_a ? IMG_A[c] : {CHUNK_W{1'b1}};
            ld_valid = 1'b1;
            ld_data  = img[c];
            @(negedge clk);
            if (poke_req) check(rsp_valid == 1'b0, "R8 during load", int'(rsp_valid), 0);
        end
        ld_valid  = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic lookup_check(input int idx, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = IDX_W'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {tag, " R5 valid"}, int'(rsp_valid), 1);
        check(rsp_bit == model_bit(idx), {tag, " R2 bit"}, int'(rsp_bit), int'(model_bit(idx)));
        check(int'(rsp_excl) == model_rank(idx, 1'b0), {tag, " R3 excl"},
              int'(rsp_excl), model_rank(idx, 1'b0));
        check(int'(rsp_incl) == model_rank(idx, 1'b1), {tag, " R4 incl"},
              int'(rsp_incl), model_rank(idx, 1'b1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R10 valid", int'(rsp_valid), 0);
        check(rsp_excl == '0 && rsp_incl == '0 && rsp_bit == 1'b0, "R10 data",
              int'(rsp_incl), 0);
        rst_n = 1'b1;

        // R6 R8: load image A with requests held high throughout
        do_load(1'b1, 1'b1);

        // R1 R2 R3 R4 table walk; R7 first lookup right after load
        for (int i = 0; i < NLOOK; i++) lookup_check(int'(LOOK_IDX[i]), "table");

        // R5 single strobe per request
        @(negedge clk);
        check(rsp_valid == 1'b0, "R5 strobe drops", int'(rsp_valid), 0);

        // R5 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_idx = 8'd97;
        @(negedge clk);
        req_idx = 8'd200;
        check(rsp_valid && int'(rsp_excl) == model_rank(97, 1'b0), "R5 b2b first",
              int'(rsp_excl), model_rank(97, 1'b0));
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && int'(rsp_incl) == model_rank(200, 1'b1), "R5 b2b second",
              int'(rsp_incl), model_rank(200, 1'b1));
        @(negedge clk);
        check(rsp_valid == 1'b0, "R5 b2b end", int'(rsp_valid), 0);

        // R9 ld_valid in idle writes nothing
        ld_valid = 1'b1; ld_data = '0;
        @(negedge clk);
        ld_valid = 1'b0;
        lookup_check(31, "R9 idle write");
        lookup_check(3, "R1 msb-first");

        // R11 R6 reload all ones: running sum restarts, full rank reached
        do_load(1'b0, 1'b0);
        lookup_check(255, "R11 full");
        check(int'(rsp_incl) == 256, "R11 width", int'(rsp_incl), 256);
        lookup_check(40, "R6 reload");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule